// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator with Infrared Mode

This block turns the bus clock into the two timing strobes that an asynchronous serial port needs. One strobe is an oversample tick, which comes sixteen times per bit. The other is a bit-period tick. A 13-bit rate field and an infrared-mode bit set the rate.

In normal mode the oversample tick comes once every `rate_div` bus cycles, so one bit lasts 16 × `rate_div` cycles. In infrared mode the lowest bit of the field is dropped and the upper twelve bits form the divisor. The oversample count per bit doubles to 32, so one bit lasts 32 × `rate_div[12:1]` cycles.

An effective divisor of zero stops the generator: both counters stay at zero and no tick is produced. Any change to the field or to the mode bit restarts both counters from zero.

Top module: `uart_rate_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `bit_tick` are both 0.
- R2: In normal mode (`irda_en`=0) with a field value D greater than 0, `os_tick` is a one-cycle pulse. It first appears D cycles after the cycle in which the setting is first presented, and then every D cycles.
- R3: In normal mode, `bit_tick` pulses together with every 16th `os_tick`, counted from the restart.
- R4: In infrared mode (`irda_en`=1), `os_tick` pulses every `rate_div[12:1]` cycles. `bit_tick` pulses together with every 32nd `os_tick`.
- R5: In infrared mode, bit 0 of `rate_div` has no effect on the rate. After a restart, field values 2k and 2k+1 give the same tick pattern.
- R6: A field value of 0 holds both ticks at 0 for as long as it is applied.
- R7: In infrared mode, a field value of 0 or 1 (upper twelve bits all zero) holds both ticks at 0.
- R8: Any change of `rate_div` or `irda_en` gives no tick in that cycle. Both counters then restart from zero, so timing follows R2–R4 as if the setting were new. This also applies when only the mode changes.
- R9: `bit_tick` is never 1 in a cycle where `os_tick` is 0.
- R10: The largest field value, 8191, gives an `os_tick` every 8191 cycles without counter overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_div | input | 13 | Rate divisor field |
| irda_en | input | 1 | 1 selects infrared timing, 0 selects normal timing |
| os_tick | output | 1 | Oversample strobe, one cycle wide |
| bit_tick | output | 1 | Bit-period strobe, one cycle wide |

## Verification
The hardest case to reach is a restart that hits a partly counted bit. That includes a change in which only the mode bit toggles while the field stays fixed, and an infrared change that touches only bit 0. In each of these the old rate and the new rate overlap. The stimulus applies a setting, waits a number of cycles that is not a multiple of the oversample period, and then changes one input. A behavioural model tracks the elapsed cycles since each restart and checks every clock against the design.

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int DIV_W = 13,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             irda_en,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int OS_W = $clog2(2 * OVS);

  logic [DIV_W-1:0] div_q;
  logic             irda_q;
  logic [DIV_W-1:0] pre_cnt;
  logic [OS_W-1:0]  os_cnt;

  wire             changed = (rate_div != div_q) || (irda_en != irda_q);
  wire [DIV_W-1:0] eff     = irda_en ? {1'b0, rate_div[DIV_W-1:1]} : rate_div;
  wire             run     = (eff != '0) && !changed;
  wire [OS_W-1:0]  os_last = irda_en ? OS_W'(2 * OVS - 1) : OS_W'(OVS - 1);

  assign os_tick  = run && (pre_cnt == eff - 1'b1);
  assign bit_tick = os_tick && (os_cnt == os_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      irda_q  <= 1'b0;
      pre_cnt <= '0;
      os_cnt  <= '0;
    end else begin
      div_q  <= rate_div;
      irda_q <= irda_en;
      if (!run) begin
        pre_cnt <= '0;
        os_cnt  <= '0;
      end else if (os_tick) begin
        pre_cnt <= '0;
        os_cnt  <= bit_tick ? '0 : os_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R10: prescaler stays below the divisor
  a_r10_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt < eff));

  // R4: oversample count stays within the mode's count per bit
  a_r4_os_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (os_cnt <= os_last));

  // R8: a setting change clears both counters
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (pre_cnt == '0 && os_cnt == '0));

  // R6: a zero divisor keeps the counters idle
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |=> (pre_cnt == '0 && os_cnt == '0));

  // R2: prescaler wraps after each oversample tick
  a_r2_os_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> (pre_cnt == '0));

  // R3: oversample count wraps after each bit tick
  a_r3_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (os_cnt == '0));
endmodule

// File: tb/sim_uart_rate_gen.sv
module sim_uart_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] rate_div = '0;
  logic        irda_en = 1'b0;
  logic        os_tick, bit_tick;

  int tests = 0, fails = 0, cycles = 0;
  int m_t = 0, m_div = 0, m_ir = 0;
  int n_os = 0, n_bit = 0;
  string req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rate_gen u0 (.clk(clk), .rst_n(rst_n), .rate_div(rate_div),
                    .irda_en(irda_en), .os_tick(os_tick), .bit_tick(bit_tick));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cyc();
    int d, n;
    bit eo, eb, live;
    #1;
    d = irda_en ? int'(rate_div) / 2 : int'(rate_div);
    n = irda_en ? 32 : 16;
    live = rst_n && (int'(rate_div) == m_div) && (int'(irda_en) == m_ir) && d > 0;
    eo = live && ((m_t + 1) % d == 0);
    eb = live && ((m_t + 1) % (d * n) == 0);
    tests++;
    if (os_tick !== eo || bit_tick !== eb) begin
      fails++;
      $display("FAIL %s: os_tick=%0b bit_tick=%0b expected %0b %0b", req, os_tick, bit_tick, eo, eb);
    end
    if (!rst_n) begin
      tests++;
      if (os_tick !== 1'b0 || bit_tick !== 1'b0) begin
        fails++;
        $display("FAIL R1: ticks %0b%0b in reset, expected 00", os_tick, bit_tick);
      end
    end
    if (bit_tick && !os_tick) begin
      fails++;
      $display("FAIL R9: bit_tick=1 os_tick=0, expected os_tick=1");
    end
    n_os  += int'(os_tick);
    n_bit += int'(bit_tick);
    @(posedge clk);
    if (!rst_n) begin
      m_t = 0; m_div = 0; m_ir = 0;
    end else begin
      m_t = live ? m_t + 1 : 0;
      m_div = int'(rate_div);
      m_ir = int'(irda_en);
    end
    @(negedge clk);
  endtask

  task automatic phase(string r, int div, bit ir, int len, int eos, int ebit);
    req = r;
    rate_div = 13'(div);
    irda_en = ir;
    n_os = 0; n_bit = 0;
    for (int i = 0; i < len; i++) cyc();
    tests++;
    if (n_os != eos || n_bit != ebit) begin
      fails++;
      $display("FAIL %s: os=%0d bit=%0d expected os=%0d bit=%0d", r, n_os, n_bit, eos, ebit);
    end
  endtask

  initial begin
    @(negedge clk);
    req = "R1";
    rate_div = 13'd1;
    for (int i = 0; i < 6; i++) cyc();
    rst_n = 1'b1;
    rate_div = '0;
    cyc();
    phase("R2", 1, 0, 1 + 16 * 2, 32, 2);
    phase("R3", 3, 0, 1 + 48 * 3, 48, 3);
    phase("R6", 0, 0, 500, 0, 0);
    phase("R4", 4, 1, 1 + 64 * 2, 64, 2);
    phase("R5", 5, 1, 1 + 64 * 2, 64, 2);
    phase("R7", 1, 1, 300, 0, 0);
    phase("R7", 0, 1, 50, 0, 0);
    phase("R8", 5, 0, 37, 7, 0);
    phase("R8", 2, 0, 1 + 32, 16, 1);
    phase("R8", 8, 0, 45, 5, 0);
    phase("R8", 8, 1, 1 + 128, 32, 1);
    phase("R8", 8, 0, 1 + 128 * 2, 32, 2);
    phase("R10", 8191, 0, 1 + 8191 * 3, 3, 0);
    phase("R2", 7, 0, 1 + 112, 16, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule